// File: doc/BRIEF.md
# Gated Coincidence Pattern Register

The block latches a 48-bit hit pattern. An input bit is recorded as 1 when that input is high in a clock cycle in which the common gate is high and the gate is not blocked by the inhibit. Recorded bits stay set until a clear removes them. The 48 bits are held in three independent 16-bit groups. Each group drives a count of its set bits, which stands in for a majority sum and can feed a fast trigger decision. A look-at-me (LAM) flag is the OR of the set bits of every group that software has enabled.

Software uses a command channel modelled on a crate dataway. A command carries a function code and a group subaddress, and it travels over a valid/ready handshake. Every accepted command returns exactly one response word and a Q flag on a second valid/ready channel. That response register holds a single entry. A new command is accepted only when the response register is empty or is being emptied in the same cycle. A response stays stable until the consumer takes it.

A front-panel clear empties all groups. If the clear is held while the gate is open, the groups load only the present coincidence on every cycle. The block then works as a transparent coincidence and majority unit. All inputs are treated as samples taken on the clock.

Top module: `coinc_pattern_reg`

## Requirements
- R1: A register bit is set on the clock edge at which its input and the gate are both high and the inhibit is low. The bit stays set until a clear removes it.
- R2: Inputs 15:0 form group A (subaddress 0), inputs 31:16 form group B (subaddress 1) and inputs 47:32 form group C (subaddress 2). The majority output for group g at bits 5g+4:5g equals the number of set bits in that group.
- R3: Function 0 with subaddress 0–2 returns the selected group on the response data with Q=1. It leaves every register unchanged.
- R4: Function 2 with subaddress 0–2 returns the value the group held before the command, with Q=1, and clears that group. A coincidence captured in the same cycle is still set afterwards.
- R5: Function 9 with subaddress 0–2 clears only that group. Function 11 with subaddress 0–2 clears all three groups. Both return Q=1 and data 0. A coincidence captured in the same cycle is still set afterwards.
- R6: A front-panel clear with the gate closed empties all groups, even if inputs are high. A front-panel clear with the gate open makes every group load exactly the present coincidence, so earlier hits are dropped.
- R7: While the inhibit is high, the gate has no effect. Nothing is captured, and an active front-panel clear empties the groups.
- R8: The crate clear/initialise input empties all groups on the next edge. It overrides capture and every other update in that cycle.
- R9: LAM is high when any enabled group has a set bit. Enable bit g of the enable input selects group g. Function 8 with subaddress 0–2 returns Q equal to the LAM level before the command, with data 0.
- R10: Any other function code, or any subaddress of 3 or above, returns Q=0 and data 0 and changes no register.
- R11: The command ready signal equals NOT response-valid OR response-ready. While the response is valid and not taken, its data and Q hold.
- R12: After reset all groups, all counts, LAM and response-valid are 0, and the command ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 48 | Hit inputs, bit 0 is input 1 |
| gate_i | input | 1 | Common coincidence gate |
| fp_clear_i | input | 1 | Front-panel clear / overlap mode when gate is open |
| inhibit_i | input | 1 | Blocks the gate |
| crate_init_i | input | 1 | Clear-all command from the crate |
| lam_en_i | input | 3 | Per-group LAM enable (bit 0 = A) |
| cmd_valid_i | input | 1 | Command valid |
| cmd_ready_o | output | 1 | Command ready |
| cmd_func_i | input | 5 | Function code |
| cmd_sub_i | input | 4 | Subaddress |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response taken |
| rsp_data_o | output | 16 | Response data |
| rsp_q_o | output | 1 | Q flag of the response |
| maj_o | output | 15 | Three 5-bit set-bit counts, group A in the low bits |
| lam_o | output | 1 | Look-at-me |

## Verification
The collision that matters is a command clear (read-and-clear, group clear or clear-all) landing in the same cycle as a new gated capture. The bench causes it by issuing random commands while the gate and hits are also random, and by directed cycles that aim a read-and-clear at a group that is receiving hits. A reference model in the bench predicts the returned pre-clear word, and it predicts that the fresh bits survive. The counts, LAM and later reads confirm that. A second overlap, between the front-panel clear and an open gate, is judged the same way: the counts must equal only the present coincidence.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int GRP_W_DEF = 16;
  localparam int N_GRP_DEF = 3;
  localparam int FUNC_W    = 5;
  localparam int SUB_W     = 4;

  typedef enum logic [FUNC_W-1:0] {
    FN_READ     = 5'd0,
    FN_READ_CLR = 5'd2,
    FN_TEST_LAM = 5'd8,
    FN_CLR_GRP  = 5'd9,
    FN_CLR_ALL  = 5'd11
  } cpr_fn_e;
endpackage

// File: rtl/cpr_group.sv
module cpr_group #(
  parameter int W     = 16,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     coin_i,
  input  logic             fp_clr_i,
  input  logic             cmd_clr_i,
  input  logic             init_i,
  output logic [W-1:0]     pat_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0] pat_q, pat_d;

  always_comb begin
    if (init_i)                    pat_d = '0;
    else if (fp_clr_i)             pat_d = coin_i;
    else if (cmd_clr_i)            pat_d = coin_i;
    else                           pat_d = pat_q | coin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pat_q <= '0;
    else        pat_q <= pat_d;
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CNT_W'(pat_q[i]);
  end

  assign pat_o = pat_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !fp_clr_i && !cmd_clr_i && coin_i == '0) |=> $stable(pat_q)); // R1
  AST_CAPTURE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && coin_i != '0) |=> ((pat_q & $past(coin_i)) == $past(coin_i))); // R1
  AST_INIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (pat_q == '0)); // R8
endmodule

// File: rtl/cpr_cmd.sv
module cpr_cmd
  import cpr_pkg::*;
#(
  parameter int N_GRP = 3,
  parameter int W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [FUNC_W-1:0]  func_i,
  input  logic [SUB_W-1:0]   sub_i,
  input  logic               rsp_ready_i,
  output logic               rsp_valid_o,
  output logic [W-1:0]       rsp_data_o,
  output logic               rsp_q_o,
  input  logic [N_GRP*W-1:0] pat_i,
  input  logic               lam_i,
  output logic [N_GRP-1:0]   clr_o
);
  logic         accept, sub_ok;
  logic [W-1:0] sel_pat, data_d;
  logic         q_d, vld_q, q_q;
  logic [W-1:0] data_q;

  assign cmd_ready_o = !vld_q || rsp_ready_i;
  assign accept      = cmd_valid_i && cmd_ready_o;
  assign sub_ok      = sub_i < SUB_W'(N_GRP);

  always_comb begin
    sel_pat = '0;
    for (int g = 0; g < N_GRP; g++)
      if (sub_i == SUB_W'(g)) sel_pat = pat_i[g*W +: W];
  end

  always_comb begin
    for (int g = 0; g < N_GRP; g++)
      clr_o[g] = accept && sub_ok &&
                 ((func_i == FN_CLR_ALL) ||
                  (((func_i == FN_READ_CLR) || (func_i == FN_CLR_GRP)) && sub_i == SUB_W'(g)));
  end

  always_comb begin
    data_d = '0;
    q_d    = 1'b0;
    if (sub_ok) begin
      case (func_i)
        FN_READ, FN_READ_CLR: begin data_d = sel_pat; q_d = 1'b1; end
        FN_CLR_GRP, FN_CLR_ALL: q_d = 1'b1;
        FN_TEST_LAM: q_d = lam_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      q_q    <= 1'b0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      data_q <= data_d;
      q_q    <= q_d;
    end else if (rsp_ready_i) begin
      vld_q  <= 1'b0;
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_data_o  = data_q;
  assign rsp_q_o     = q_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !rsp_ready_i) |=> (vld_q && $stable(data_q) && $stable(q_q))); // R11
  AST_BAD_SUB_NO_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sub_ok) |=> (!q_q && data_q == '0)); // R10
  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> vld_q); // R11
endmodule

// File: rtl/coinc_pattern_reg.sv
module coinc_pattern_reg
  import cpr_pkg::*;
#(
  parameter int GRP_W = GRP_W_DEF,
  parameter int N_GRP = N_GRP_DEF,
  localparam int IN_W  = GRP_W * N_GRP,
  localparam int CNT_W = $clog2(GRP_W + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IN_W-1:0]        hit_i,
  input  logic                   gate_i,
  input  logic                   fp_clear_i,
  input  logic                   inhibit_i,
  input  logic                   crate_init_i,
  input  logic [N_GRP-1:0]       lam_en_i,
  input  logic                   cmd_valid_i,
  output logic                   cmd_ready_o,
  input  logic [FUNC_W-1:0]      cmd_func_i,
  input  logic [SUB_W-1:0]       cmd_sub_i,
  output logic                   rsp_valid_o,
  input  logic                   rsp_ready_i,
  output logic [GRP_W-1:0]       rsp_data_o,
  output logic                   rsp_q_o,
  output logic [N_GRP*CNT_W-1:0] maj_o,
  output logic                   lam_o
);
  logic [IN_W-1:0]  coin;
  logic [IN_W-1:0]  pat;
  logic [N_GRP-1:0] grp_clr;
  logic [N_GRP-1:0] grp_any;

  assign coin = (gate_i && !inhibit_i) ? hit_i : '0;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    cpr_group #(.W(GRP_W)) u_grp (
      .clk       (clk),
      .rst_n     (rst_n),
      .coin_i    (coin[g*GRP_W +: GRP_W]),
      .fp_clr_i  (fp_clear_i),
      .cmd_clr_i (grp_clr[g]),
      .init_i    (crate_init_i),
      .pat_o     (pat[g*GRP_W +: GRP_W]),
      .cnt_o     (maj_o[g*CNT_W +: CNT_W])
    );
    assign grp_any[g] = |pat[g*GRP_W +: GRP_W];
  end

  assign lam_o = |(grp_any & lam_en_i);

  cpr_cmd #(.N_GRP(N_GRP), .W(GRP_W)) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_i (cmd_valid_i),
    .cmd_ready_o (cmd_ready_o),
    .func_i      (cmd_func_i),
    .sub_i       (cmd_sub_i),
    .rsp_ready_i (rsp_ready_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .rsp_q_o     (rsp_q_o),
    .pat_i       (pat),
    .lam_i       (lam_o),
    .clr_o       (grp_clr)
  );

  AST_LAM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (lam_en_i == '0) |-> !lam_o); // R9
  AST_FPC_NO_GATE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_clear_i && !gate_i) |=> (maj_o == '0)); // R6
  AST_INHIBIT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_i && !fp_clear_i && !crate_init_i) |=> ((pat & ~$past(pat)) == '0)); // R7
endmodule

// File: tb/coinc_pattern_reg_tb.sv
module coinc_pattern_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] hit_i = '0;
  logic        gate_i = 0, fp_clear_i = 0, inhibit_i = 0, crate_init_i = 0;
  logic [2:0]  lam_en_i = 3'b111;
  logic        cmd_valid_i = 0, rsp_ready_i = 1;
  logic [4:0]  cmd_func_i = '0;
  logic [3:0]  cmd_sub_i = '0;
  logic        cmd_ready_o, rsp_valid_o, rsp_q_o, lam_o;
  logic [15:0] rsp_data_o;
  logic [14:0] maj_o;

  int n_cmp = 0, n_bad = 0, n_cyc = 0;
  logic [15:0] m [3];
  logic        m_rv, m_q;
  logic [15:0] m_d;
  string       m_tag;

  always #2.5 clk = ~clk;

  coinc_pattern_reg u_dut (
    .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .gate_i(gate_i), .fp_clear_i(fp_clear_i),
    .inhibit_i(inhibit_i), .crate_init_i(crate_init_i), .lam_en_i(lam_en_i),
    .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o), .cmd_func_i(cmd_func_i),
    .cmd_sub_i(cmd_sub_i), .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i),
    .rsp_data_o(rsp_data_o), .rsp_q_o(rsp_q_o), .maj_o(maj_o), .lam_o(lam_o));

  task automatic check(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int pop16(logic [15:0] v);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic model_lam();
    logic l = 1'b0;
    for (int g = 0; g < 3; g++) if (lam_en_i[g] && m[g] != 0) l = 1'b1;
    return l;
  endfunction

  task automatic step(logic [47:0] h, logic g, logic fpc, logic inh, logic ini,
                      logic cv, logic [4:0] f, logic [3:0] s, logic rr);
    logic [47:0] coin;
    logic acc, sok, lam0;
    logic [2:0] clr;
    string tg;
    hit_i = h; gate_i = g; fp_clear_i = fpc; inhibit_i = inh; crate_init_i = ini;
    cmd_valid_i = cv; cmd_func_i = f; cmd_sub_i = s; rsp_ready_i = rr;
    #1;
    check("R11", "cmd_ready", cmd_ready_o, (!m_rv || rr));
    coin = (g && !inh) ? h : '0;
    acc = cv && (!m_rv || rr);
    sok = s < 3;
    lam0 = model_lam();
    clr = '0;
    if (acc && sok) begin
      if (f == 5'd11) clr = 3'b111;
      else if (f == 5'd2 || f == 5'd9) clr[s[1:0]] = 1'b1;
    end
    if (acc) begin
      m_rv = 1'b1; m_d = '0; m_q = 1'b0; m_tag = "R10";
      if (sok) begin
        case (f)
          5'd0:  begin m_d = m[s[1:0]]; m_q = 1'b1; m_tag = "R3"; end
          5'd2:  begin m_d = m[s[1:0]]; m_q = 1'b1; m_tag = "R4"; end
          5'd9, 5'd11: begin m_q = 1'b1; m_tag = "R5"; end
          5'd8:  begin m_q = lam0; m_tag = "R9"; end
          default: ;
        endcase
      end
    end else if (rr) m_rv = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (ini)              m[k] = '0;
      else if (fpc || clr[k]) m[k] = coin[k*16 +: 16];
      else                  m[k] = m[k] | coin[k*16 +: 16];
    end
    tg = ini ? "R8" : fpc ? "R6" : inh ? "R7" : (clr != 0) ? "R5" : "R1";
    @(posedge clk); @(negedge clk);
    n_cyc++;
    for (int k = 0; k < 3; k++)
      check(tg, $sformatf("count grp%0d", k), maj_o[k*5 +: 5], pop16(m[k]));
    check("R9", "lam", lam_o, model_lam());
    check("R11", "rsp_valid", rsp_valid_o, m_rv);
    if (m_rv) begin
      check(m_tag, "rsp_data", rsp_data_o, m_d);
      check(m_tag, "rsp_q", rsp_q_o, m_q);
    end
  endtask

  task automatic idle(logic [47:0] h, logic g);
    step(h, g, 0, 0, 0, 0, 5'd0, 4'd0, 1);
  endtask

  task automatic cmd(logic [4:0] f, logic [3:0] s, logic [47:0] h, logic g);
    step(h, g, 0, 0, 0, 1, f, s, 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20251));
    for (int k = 0; k < 3; k++) m[k] = '0;
    m_rv = 0; m_d = '0; m_q = 0; m_tag = "R10";
    repeat (3) @(negedge clk);
    check("R12", "reset counts", maj_o, 0);
    check("R12", "reset lam", lam_o, 0);
    check("R12", "reset rsp_valid", rsp_valid_o, 0);
    check("R12", "reset cmd_ready", cmd_ready_o, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 capture and hold; hits without the gate are not captured
    idle(48'h0000_0000_00F0, 0);
    idle(48'h8001_0003_0005, 1);
    idle(48'h0, 0);
    // R2 group C count at top slice
    check("R2", "grp C count", maj_o[14:10], 2);
    cmd(5'd0, 4'd2, 48'h0, 0);
    check("R3", "read C word", rsp_data_o, 16'h8001);
    // R4 read-and-clear A while new hit lands in A
    cmd(5'd2, 4'd0, 48'h0000_0000_0100, 1);
    cmd(5'd0, 4'd0, 48'h0, 0);
    check("R4", "A after rc", rsp_data_o, 16'h0100);
    // R7 inhibit blocks the gate
    step(48'hFFFF_FFFF_FFFF, 1, 0, 1, 0, 0, 5'd0, 4'd0, 1);
    // R6 overlap mode then clear with gate closed
    step(48'h0000_0F00_0001, 1, 1, 0, 0, 0, 5'd0, 4'd0, 1);
    step(48'hFFFF_FFFF_FFFF, 0, 1, 0, 0, 0, 5'd0, 4'd0, 1);
    // R8 init overrides capture
    idle(48'h1234_5678_9ABC, 1);
    step(48'hFFFF_FFFF_FFFF, 1, 0, 0, 1, 1, 5'd0, 4'd1, 1);
    // R10 unsupported function and subaddress
    idle(48'h0001_0001_0001, 1);
    cmd(5'd4, 4'd0, 48'h0, 0);
    cmd(5'd0, 4'd3, 48'h0, 0);
    cmd(5'd9, 4'd15, 48'h0, 0);
    // R9 LAM masking and test
    lam_en_i = 3'b000; cmd(5'd8, 4'd0, 48'h0, 0);
    lam_en_i = 3'b100; cmd(5'd8, 4'd1, 48'h0, 0);
    // R5 single and all clears
    cmd(5'd9, 4'd1, 48'h0, 0);
    cmd(5'd11, 4'd0, 48'h0000_0002_0000, 1);
    // R11 back-pressure: response held, second command stalls
    step(48'h0, 0, 0, 0, 0, 1, 5'd0, 4'd1, 0);
    step(48'h0, 0, 0, 0, 0, 1, 5'd9, 4'd1, 0);
    step(48'h0, 0, 0, 0, 0, 1, 5'd9, 4'd1, 0);
    step(48'h0, 0, 0, 0, 0, 0, 5'd0, 4'd0, 1);
    idle(48'h0, 0);
    lam_en_i = 3'b111;

    for (int n = 0; n < 4000; n++) begin
      logic [47:0] h;
      logic [4:0]  f;
      int          r;
      h = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      r = $urandom % 8;
      f = (r < 2) ? 5'd0 : (r < 4) ? 5'd2 : (r == 4) ? 5'd9 : (r == 5) ? 5'd11 :
          (r == 6) ? 5'd8 : 5'($urandom % 32);
      if ($urandom % 50 == 0) lam_en_i = 3'($urandom);
      step(h, ($urandom % 3) != 0, ($urandom % 40) == 0, ($urandom % 8) == 0,
           ($urandom % 150) == 0, ($urandom % 3) == 0, f,
           (($urandom % 6) == 0) ? 4'($urandom) : 4'($urandom % 3),
           ($urandom % 4) != 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule